// File: doc/BRIEF.md
# Dual-Mode Neighbor Register Queue

This block is a bank of 128 registers, 32 bits wide, that sits between two processing engines of a chain. While the block is in local mode the bank behaves as a private extension of the owning engine's general registers: that engine writes any entry by address and reads any entry by address.

While the block is in neighbor mode the same storage becomes a circular queue from the upstream engine to the downstream engine. The upstream side pushes a word at the producer (put) index. The downstream side sees the word at the consumer (get) index and pops it. Both indices can be read and loaded as control registers, so software can also use the bank as a directly indexed mailbox.

A two-state machine holds the mode. LOCAL is entered at reset. The transition LOCAL to QUEUE is taken when `mode_i` is 1, and QUEUE to LOCAL is taken when `mode_i` is 0. Each transition clears both indices. Every other operation is dropped in the cycle a transition is taken.

Top module: `nbr_queue`

## Requirements
- R1: After reset the block is in LOCAL, both indices read 0, `empty_o`=1, `full_o`=0, `err_o`=0 and `dn_valid_o`=0.
- R2: In LOCAL, `loc_we_i` writes `loc_wdata_i` to entry `loc_waddr_i`, and the value is visible on `loc_rdata_o` for `loc_raddr_i` from the next cycle. Pushes, pops and control-register writes are ignored there: the indices stay 0 and `err_o` is unchanged.
- R3: In QUEUE, an accepted push stores `up_data_i` at entry put[6:0], and the 8-bit put index then advances by 1 modulo 256.
- R4: In QUEUE, `dn_data_o` shows entry get[6:0] and `dn_valid_o` = not empty. An accepted pop advances the 8-bit get index by 1 modulo 256.
- R5: `empty_o` is 1 when put equals get. `full_o` is 1 when put[6:0] equals get[6:0] and bit 7 of the two indices differs.
- R6: A push while full, or a pop while empty, is dropped. Either one sets `err_o`, which then stays 1 until reset.
- R7: A push and a pop in the same cycle on a non-empty queue (full included) both complete in that cycle, and no error is raised.
- R8: `csr_sel_i`=0 selects put and `csr_sel_i`=1 selects get. `csr_rdata_o` shows the selected 8-bit index. In QUEUE, `csr_we_i` loads `csr_wdata_i` into the selected index, and every push and pop in that cycle is dropped.
- R9: In a cycle where `mode_i` differs from the current state, the state takes the new mode and both indices become 0. No write, push, pop or index load takes effect in that cycle.
- R10: Local writes are ignored in QUEUE. Stored words survive mode transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 selects local mode, 1 selects neighbor queue mode |
| loc_we_i | input | 1 | Local write enable |
| loc_waddr_i | input | 7 | Local write entry |
| loc_wdata_i | input | 32 | Local write data |
| loc_raddr_i | input | 7 | Local read entry |
| loc_rdata_o | output | 32 | Local read data |
| up_push_i | input | 1 | Upstream push request |
| up_data_i | input | 32 | Upstream push data |
| dn_pop_i | input | 1 | Downstream pop request |
| dn_data_o | output | 32 | Entry at the get index |
| dn_valid_o | output | 1 | Queue holds at least one word |
| csr_we_i | input | 1 | Index register write enable |
| csr_sel_i | input | 1 | 0 selects put, 1 selects get |
| csr_wdata_i | input | 8 | Index load value |
| csr_rdata_o | output | 8 | Selected index value |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| err_o | output | 1 | Sticky overflow/underflow flag |

## Verification
The assertions check on every cycle that empty and full never coincide and that `err_o` stays set once raised. They also check each one-cycle index effect: an accepted push or pop advances its index, an underflow raises the error, a combined push and pop on a full queue keeps it full without an error, an index load lands, a transition clears both indices, and LOCAL leaves the indices alone. Only the bench scenarios can show data integrity: that words come out in push order across wraparound, that the slot a rejected push would have hit keeps its old word, that local writes made in QUEUE leave the storage alone, and that stored words survive transitions.

// File: rtl/nbr_queue_pkg.sv
package nbr_queue_pkg;
    typedef enum logic {
        ST_LOCAL = 1'b0,
        ST_QUEUE = 1'b1
    } nq_state_e;
endpackage

// File: rtl/nbr_queue_store.sv
module nbr_queue_store #(
    parameter int DEPTH = 128,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [IW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [IW-1:0] raddr_a_i,
    output logic [DW-1:0] rdata_a_o,
    input  logic [IW-1:0] raddr_b_i,
    output logic [DW-1:0] rdata_b_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // two independent read ports: local side and downstream head
    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/nbr_queue_ctrl.sv
module nbr_queue_ctrl
    import nbr_queue_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mode_i,
    output logic switch_o,
    output logic loc_act_o,
    output logic q_act_o
);
    nq_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_LOCAL;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCAL: if (mode_i)  state_d = ST_QUEUE;
            ST_QUEUE: if (!mode_i) state_d = ST_LOCAL;
            default:  state_d = ST_LOCAL;
        endcase
    end

    always_comb begin
        switch_o  = 1'b0;
        loc_act_o = 1'b0;
        q_act_o   = 1'b0;
        unique case (state_q)
            ST_LOCAL: begin
                switch_o  = mode_i;
                loc_act_o = !mode_i;
            end
            ST_QUEUE: begin
                switch_o = !mode_i;
                q_act_o  = mode_i;
            end
            default: switch_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/nbr_queue_idx.sv
module nbr_queue_idx #(
    parameter int DEPTH = 128,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          q_act_i,
    input  logic          csr_we_i,
    input  logic          csr_sel_i,
    input  logic [PW-1:0] csr_wdata_i,
    input  logic          push_i,
    input  logic          pop_i,
    output logic          push_ok_o,
    output logic          pop_ok_o,
    output logic [PW-1:0] put_o,
    output logic [PW-1:0] get_o,
    output logic          empty_o,
    output logic          full_o,
    output logic          err_o
);
    logic [PW-1:0] put_q, get_q;
    logic          err_q;
    logic          qop;

    assign empty_o = (put_q == get_q);
    assign full_o  = (put_q[IW-1:0] == get_q[IW-1:0]) && (put_q[IW] != get_q[IW]);

    assign qop       = q_act_i && !csr_we_i;
    // a pop in the same cycle frees the slot, so a full queue still accepts the push
    assign push_ok_o = qop && push_i && (!full_o || pop_i);
    assign pop_ok_o  = qop && pop_i && !empty_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            put_q <= '0;
            get_q <= '0;
        end else if (clear_i) begin
            put_q <= '0;
            get_q <= '0;
        end else if (q_act_i && csr_we_i) begin
            if (csr_sel_i) get_q <= csr_wdata_i;
            else           put_q <= csr_wdata_i;
        end else begin
            if (push_ok_o) put_q <= put_q + PW'(1);
            if (pop_ok_o)  get_q <= get_q + PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) err_q <= 1'b0;
        else if ((qop && push_i && !push_ok_o) || (qop && pop_i && !pop_ok_o)) err_q <= 1'b1;
    end

    assign put_o = put_q;
    assign get_o = get_q;
    assign err_o = err_q;
endmodule

// File: rtl/nbr_queue.sv
module nbr_queue #(
    parameter int DEPTH = 128,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          mode_i,
    input  logic          loc_we_i,
    input  logic [IW-1:0] loc_waddr_i,
    input  logic [DW-1:0] loc_wdata_i,
    input  logic [IW-1:0] loc_raddr_i,
    output logic [DW-1:0] loc_rdata_o,
    input  logic          up_push_i,
    input  logic [DW-1:0] up_data_i,
    input  logic          dn_pop_i,
    output logic [DW-1:0] dn_data_o,
    output logic          dn_valid_o,
    input  logic          csr_we_i,
    input  logic          csr_sel_i,
    input  logic [PW-1:0] csr_wdata_i,
    output logic [PW-1:0] csr_rdata_o,
    output logic          empty_o,
    output logic          full_o,
    output logic          err_o
);
    logic          sw_w, loc_act_w, q_act_w;
    logic          push_ok_w, pop_ok_w;
    logic [PW-1:0] put_w, get_w;
    logic          st_we;
    logic [IW-1:0] st_waddr;
    logic [DW-1:0] st_wdata;

    nbr_queue_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mode_i    (mode_i),
        .switch_o  (sw_w),
        .loc_act_o (loc_act_w),
        .q_act_o   (q_act_w)
    );

    nbr_queue_idx #(.DEPTH(DEPTH)) u_idx (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clear_i     (sw_w),
        .q_act_i     (q_act_w),
        .csr_we_i    (csr_we_i),
        .csr_sel_i   (csr_sel_i),
        .csr_wdata_i (csr_wdata_i),
        .push_i      (up_push_i),
        .pop_i       (dn_pop_i),
        .push_ok_o   (push_ok_w),
        .pop_ok_o    (pop_ok_w),
        .put_o       (put_w),
        .get_o       (get_w),
        .empty_o     (empty_o),
        .full_o      (full_o),
        .err_o       (err_o)
    );

    // single write port: owner engine in local mode, upstream engine in queue mode
    always_comb begin
        st_we    = 1'b0;
        st_waddr = loc_waddr_i;
        st_wdata = loc_wdata_i;
        if (loc_act_w && loc_we_i) begin
            st_we = 1'b1;
        end else if (push_ok_w) begin
            st_we    = 1'b1;
            st_waddr = put_w[IW-1:0];
            st_wdata = up_data_i;
        end
    end

    nbr_queue_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (st_we),
        .waddr_i   (st_waddr),
        .wdata_i   (st_wdata),
        .raddr_a_i (loc_raddr_i),
        .rdata_a_o (loc_rdata_o),
        .raddr_b_i (get_w[IW-1:0]),
        .rdata_b_o (dn_data_o)
    );

    assign dn_valid_o  = !empty_o;
    assign csr_rdata_o = csr_sel_i ? get_w : put_w;
endmodule

// File: rtl/nbr_queue_chk.sv
module nbr_queue_chk #(
    parameter int PW = 8
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          sw_i,
    input logic          loc_act_i,
    input logic          q_act_i,
    input logic          csr_we_i,
    input logic          csr_sel_i,
    input logic [PW-1:0] csr_wdata_i,
    input logic          up_push_i,
    input logic          dn_pop_i,
    input logic          empty_i,
    input logic          full_i,
    input logic          err_i,
    input logic [PW-1:0] put_i,
    input logic [PW-1:0] get_i
);
    AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(empty_i && full_i)); // R5
    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_i |=> err_i); // R6
    AST_POP_EMPTY_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_act_i && !csr_we_i && dn_pop_i && empty_i) |=> err_i); // R6
    AST_PUSH_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_act_i && !csr_we_i && up_push_i && !full_i) |=> (put_i == $past(put_i) + PW'(1))); // R3
    AST_POP_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_act_i && !csr_we_i && dn_pop_i && !empty_i) |=> (get_i == $past(get_i) + PW'(1))); // R4
    AST_BOTH_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_act_i && !csr_we_i && up_push_i && dn_pop_i && full_i) |=> (full_i && (err_i == $past(err_i)))); // R7
    AST_CSR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_act_i && csr_we_i && !csr_sel_i) |=> (put_i == $past(csr_wdata_i))); // R8
    AST_SWITCH_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_i |=> (put_i == '0 && get_i == '0)); // R9
    AST_LOCAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        loc_act_i |=> ($stable(put_i) && $stable(get_i))); // R2
endmodule

bind nbr_queue nbr_queue_chk #(.PW(PW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_i        (sw_w),
    .loc_act_i   (loc_act_w),
    .q_act_i     (q_act_w),
    .csr_we_i    (csr_we_i),
    .csr_sel_i   (csr_sel_i),
    .csr_wdata_i (csr_wdata_i),
    .up_push_i   (up_push_i),
    .dn_pop_i    (dn_pop_i),
    .empty_i     (empty_o),
    .full_i      (full_o),
    .err_i       (err_o),
    .put_i       (put_w),
    .get_i       (get_w)
);

// File: tb/nbr_queue_tb.sv
`timescale 1ns/1ps
module nbr_queue_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic        loc_we = 1'b0;
    logic [6:0]  loc_waddr = '0;
    logic [31:0] loc_wdata = '0;
    logic [6:0]  loc_raddr = '0;
    logic [31:0] loc_rdata;
    logic        push = 1'b0;
    logic [31:0] up_data = '0;
    logic        pop = 1'b0;
    logic [31:0] dn_data;
    logic        dn_valid;
    logic        csr_we = 1'b0;
    logic        csr_sel = 1'b0;
    logic [7:0]  csr_wdata = '0;
    logic [7:0]  csr_rdata;
    logic        empty, full, err;

    int n_tot = 0;
    int n_fail = 0;
    int cyc = 0;

    // bench reference state
    logic [31:0] m_mem [128];
    logic [7:0]  m_put, m_get;
    logic        m_err, m_st;

    always #2 clk = ~clk; // 250 MHz

    nbr_queue dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
        .loc_we_i(loc_we), .loc_waddr_i(loc_waddr), .loc_wdata_i(loc_wdata),
        .loc_raddr_i(loc_raddr), .loc_rdata_o(loc_rdata),
        .up_push_i(push), .up_data_i(up_data),
        .dn_pop_i(pop), .dn_data_o(dn_data), .dn_valid_o(dn_valid),
        .csr_we_i(csr_we), .csr_sel_i(csr_sel), .csr_wdata_i(csr_wdata),
        .csr_rdata_o(csr_rdata),
        .empty_o(empty), .full_o(full), .err_o(err)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_tot++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic is_empty();
        return m_put == m_get;
    endfunction
    function automatic logic is_full();
        return (m_put[6:0] == m_get[6:0]) && (m_put[7] != m_get[7]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 128; i++) m_mem[i] = '0;
        m_put = '0; m_get = '0; m_err = 1'b0; m_st = 1'b0;
    endtask

    // next state of the reference, from the inputs present at this edge
    task automatic model_step();
        logic e, f, wok, pok;
        if (mode != m_st) begin
            m_st = mode; m_put = '0; m_get = '0;            // R9
        end else if (!m_st) begin
            if (loc_we) m_mem[loc_waddr] = loc_wdata;       // R2
        end else if (csr_we) begin
            if (csr_sel) m_get = csr_wdata; else m_put = csr_wdata; // R8
        end else begin
            e = is_empty(); f = is_full();
            wok = push && (!f || pop);                      // R7
            pok = pop && !e;
            if ((push && !wok) || (pop && !pok)) m_err = 1'b1; // R6
            if (wok) begin m_mem[m_put[6:0]] = up_data; m_put = m_put + 8'd1; end
            if (pok) m_get = m_get + 8'd1;
        end
    endtask

    task automatic check_all();
        chk("R5 empty", {31'd0, empty}, {31'd0, is_empty()});
        chk("R5 full", {31'd0, full}, {31'd0, is_full()});
        chk("R6 err", {31'd0, err}, {31'd0, m_err});
        chk("R4 dn_valid", {31'd0, dn_valid}, {31'd0, !is_empty()});
        chk("R4 dn_data", dn_data, m_mem[m_get[6:0]]);
        chk("R2 loc_rdata", loc_rdata, m_mem[loc_raddr]);
        chk("R8 csr_rdata", {24'd0, csr_rdata}, {24'd0, csr_sel ? m_get : m_put});
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        check_all();
        loc_we = 1'b0; push = 1'b0; pop = 1'b0; csr_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        mode = 1'b0;
        model_reset();
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd2718));
        do_reset();
        #1;
        // R1 reset state
        chk("R1 empty", {31'd0, empty}, 32'd1);
        chk("R1 full", {31'd0, full}, 32'd0);
        chk("R1 err", {31'd0, err}, 32'd0);
        chk("R1 dn_valid", {31'd0, dn_valid}, 32'd0);
        chk("R1 put", {24'd0, csr_rdata}, 32'd0);

        // R2 local writes, queue ops ignored in LOCAL
        for (int i = 0; i < 8; i++) begin
            loc_we = 1'b1; loc_waddr = 7'(i * 17); loc_wdata = 32'hA000_0000 + i;
            tick();
        end
        loc_raddr = 7'd34; tick();
        chk("R2 readback", loc_rdata, 32'hA000_0002);
        push = 1'b1; pop = 1'b1; csr_we = 1'b1; csr_wdata = 8'h55; tick();
        chk("R2 err unchanged", {31'd0, err}, 32'd0);
        chk("R2 put held", {24'd0, csr_rdata}, 32'd0);

        // R9 switch cycle drops the push, R10 data survives
        mode = 1'b1; push = 1'b1; up_data = 32'hDEAD_0001; tick();
        chk("R9 put zero", {24'd0, csr_rdata}, 32'd0);
        chk("R9 empty", {31'd0, empty}, 32'd1);
        loc_raddr = 7'd17; tick();
        chk("R10 survives", loc_rdata, 32'hA000_0001);
        loc_we = 1'b1; loc_waddr = 7'd17; loc_wdata = 32'h1234_5678; tick();
        chk("R10 write ignored", loc_rdata, 32'hA000_0001);

        // R6 pop on empty
        pop = 1'b1; tick();
        chk("R6 underflow err", {31'd0, err}, 32'd1);
        do_reset();
        mode = 1'b1; tick();

        // R3 fill to full
        for (int i = 0; i < 128; i++) begin
            push = 1'b1; up_data = 32'hC000_0000 + i; tick();
        end
        csr_sel = 1'b0; #0;
        chk("R3 put wrapped", {24'd0, csr_rdata}, 32'h80);
        chk("R5 full", {31'd0, full}, 32'd1);
        push = 1'b1; up_data = 32'hBAD0_BAD0; tick();
        chk("R6 overflow err", {31'd0, err}, 32'd1);
        chk("R6 slot kept", dn_data, 32'hC000_0000);
        push = 1'b1; pop = 1'b1; up_data = 32'h7777_0000; tick();
        chk("R7 still full", {31'd0, full}, 32'd1);
        chk("R7 head moved", dn_data, 32'hC000_0001);

        // R8 load get index
        csr_we = 1'b1; csr_sel = 1'b1; csr_wdata = 8'h80; push = 1'b1; tick();
        chk("R8 get loaded", {24'd0, csr_rdata}, 32'h80);
        chk("R8 head at 0", dn_data, 32'h7777_0000);

        // constrained random mix
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 199));
            if (r == 0) mode = ~mode;
            loc_we    = ($urandom_range(0, 3) == 0);
            loc_waddr = 7'($urandom);
            loc_wdata = $urandom;
            loc_raddr = 7'($urandom);
            push      = ($urandom_range(0, 99) < ((i / 500) % 2 == 0 ? 70 : 30));
            up_data   = $urandom;
            pop       = ($urandom_range(0, 99) < ((i / 500) % 2 == 0 ? 30 : 70));
            csr_sel   = $urandom_range(0, 1) == 1;
            csr_we    = ($urandom_range(0, 63) == 0);
            csr_wdata = 8'($urandom);
            tick();
        end
        summary();
    end
endmodule